// File: doc/BRIEF.md
# USB Device Interrupt Status Aggregator

This block gathers the interrupt sources of a USB device controller into one read-only device status word. It then produces the interrupt lines that a processor sees. A start-of-frame tick, endpoint events, bus state changes and the two command-register handshake flags each set their own status bit. Endpoint events are sorted onto a fast bit or a slow bit by a per-endpoint priority mask. Software acknowledges the event bits through a write-one-to-clear register. It selects which pending bits may interrupt through a mask register, and a global enable bit gates the combined interrupt output.

The block also keeps a "clock needed" flag. Any bus activity or finished frame sets the flag. It falls after a fixed number of millisecond ticks with no new activity, and each new activity starts the count again. When the flag rises, a one-cycle wakeup request is issued, but only if bus-activity wakeup is enabled. The top-level summary word shows this flag beside the global enable.

Top module: `usbIntAggregator`

## Requirements
- R1: A `frameTick` pulse sets device status bit 0 at the next clock edge.
- R2: An endpoint event whose `epPriority` bit is 1 sets status bit 1 (fast). An event whose priority bit is 0 sets status bit 2 (slow). Events of both kinds in one cycle set both bits.
- R3: A `busReset`, `suspendChange` or `connectChange` pulse sets status bit 3.
- R4: Status bit 4 is `cmdEmpty` and status bit 5 is `cmdFull`, each registered with one cycle of delay. Bit 4 resets to 1 and bit 5 resets to 0.
- R5: After reset the outputs are as follows: `devStatus` = 0x0000_0010, `topStatus` = 0x8000_0000, `intMask` = 0, and `irqOut`, `fastIrq`, `slowIrq` and `wakeReq` are all 0. `devStatus` bits 31:6 always read 0.
- R6: A write with `regSel` = 0 clears each status bit i (0 to 3) for which `wrData[i]` is 1, at the next edge. Bits 4 and 5 are unaffected. When a bit is set and cleared in the same cycle, it ends up set.
- R7: A write with `regSel` = 1 loads `intMask` from `wrData[5:0]`. `fastIrq` equals status bit 1 AND mask bit 1. `slowIrq` equals status bit 2 AND mask bit 2.
- R8: `irqOut` equals `topStatus[31]` AND the OR over bits 5:0 of (status AND mask).
- R9: A write with `regSel` = 2 loads only `topStatus[31]` (global enable) from `wrData[31]`. The layout of `topStatus` is: bit 31 enable, bit 8 clock-needed flag, bit 0 ungated OR of (status AND mask). All other bits read 0, and writes to them have no effect.
- R10: The clock-needed flag (`topStatus[8]`) is 1 after any edge that samples `busActivity` or `frameDone`. While no new activity arrives, it falls at the edge that samples the HOLD_MS-th `msTick` (3 by default). Activity sampled at the same edge as a tick restarts the count.
- R11: `wakeReq` is 1 for exactly the one cycle after the clock-needed flag rises, and only if `wakeEnable` is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | Start-of-frame pulse, once per ms |
| epEvent | input | NUM_EP | Per-endpoint interrupt event pulses |
| epPriority | input | NUM_EP | Per-endpoint fast (1) / slow (0) routing mask |
| busReset | input | 1 | Bus reset detected pulse |
| suspendChange | input | 1 | Suspend state changed pulse |
| connectChange | input | 1 | Connect state changed pulse |
| cmdEmpty | input | 1 | Command code register empty level |
| cmdFull | input | 1 | Command data register full level |
| busActivity | input | 1 | Activity seen on bus data lines |
| frameDone | input | 1 | Frame received or sent strobe |
| msTick | input | 1 | One-millisecond timebase pulse |
| wakeEnable | input | 1 | Allow bus activity to request wakeup |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 clear, 1 mask, 2 top-level |
| wrData | input | 32 | Register write data |
| devStatus | output | 32 | Device interrupt status word |
| topStatus | output | 32 | Top-level summary and enable word |
| intMask | output | 6 | Interrupt enable mask readback |
| fastIrq | output | 1 | Masked fast endpoint interrupt line |
| slowIrq | output | 1 | Masked slow endpoint interrupt line |
| irqOut | output | 1 | Gated combined interrupt |
| wakeReq | output | 1 | Wakeup request pulse |

## Verification
Two operations can land on the same edge and must be resolved correctly. The first is an event that sets a status bit arriving together with a software clear of that bit. The bench walks every combination of a preset pattern, a set pattern and a clear pattern over bits 0 to 3. It checks that each bit ends as set OR (preset AND NOT clear). The second is a millisecond tick arriving together with fresh bus activity. The bench makes the two coincide after the countdown is nearly spent, then checks that the clock-needed flag survives and that a full new hold interval of ticks is needed before it falls.

// File: rtl/usbIntPkg.sv
package usbIntPkg;
  typedef enum logic [1:0] {
    SEL_CLEAR = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_TOP   = 2'd2
  } regSel_e;

  localparam int EVT_BITS  = 4;
  localparam int STAT_BITS = 6;

  typedef struct packed {
    logic [EVT_BITS-1:0] clrBits;
    logic                maskLoad;
    logic                enLoad;
  } ctlStrobe_t;
endpackage

// File: rtl/usbIntCtrl.sv
module usbIntCtrl
  import usbIntPkg::*;
#(
  parameter int HOLD_MS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [1:0]          regSel,
  input  logic [EVT_BITS-1:0] wrLow,
  input  logic                busActivity,
  input  logic                frameDone,
  input  logic                msTick,
  input  logic                wakeEnable,
  output ctlStrobe_t          strobe,
  output logic                needClock,
  output logic                wakeReq
);
  localparam int CNT_W = $clog2(HOLD_MS + 1);

  logic [CNT_W-1:0] msLeft;
  logic             needPrev;
  logic             reload;

  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      case (regSel_e'(regSel))
        SEL_CLEAR: strobe.clrBits  = wrLow;
        SEL_MASK:  strobe.maskLoad = 1'b1;
        SEL_TOP:   strobe.enLoad   = 1'b1;
        default:   strobe = '0;
      endcase
    end
  end

  assign reload = busActivity | frameDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      needClock <= 1'b0;
      needPrev  <= 1'b0;
      msLeft    <= '0;
    end else begin
      needPrev <= needClock;
      if (reload) begin
        needClock <= 1'b1;
        msLeft    <= CNT_W'(HOLD_MS);
      end else if (needClock && msTick) begin
        if (msLeft <= CNT_W'(1)) begin
          needClock <= 1'b0;
          msLeft    <= '0;
        end else begin
          msLeft <= msLeft - CNT_W'(1);
        end
      end
    end
  end

  assign wakeReq = wakeEnable & needClock & ~needPrev;

  assert_activity_sets_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busActivity || frameDone) |=> needClock);
  assert_drop_on_tick_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(needClock) |-> ($past(msTick) && !$past(busActivity) && !$past(frameDone)));
  assert_wake_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> !wakeReq);
endmodule

// File: rtl/usbIntDatapath.sv
module usbIntDatapath
  import usbIntPkg::*;
#(
  parameter int NUM_EP = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  logic [STAT_BITS-1:0] wrMask,
  input  logic                 wrEnable,
  input  logic                 frameTick,
  input  logic [NUM_EP-1:0]    epEvent,
  input  logic [NUM_EP-1:0]    epPriority,
  input  logic                 busReset,
  input  logic                 suspendChange,
  input  logic                 connectChange,
  input  logic                 cmdEmpty,
  input  logic                 cmdFull,
  input  logic                 needClock,
  output logic [31:0]          devStatus,
  output logic [31:0]          topStatus,
  output logic [STAT_BITS-1:0] intMask,
  output logic                 fastIrq,
  output logic                 slowIrq,
  output logic                 irqOut
);
  logic [EVT_BITS-1:0]  setVec;
  logic [EVT_BITS-1:0]  evtBits;
  logic                 cmdEmptyQ;
  logic                 cmdFullQ;
  logic                 globalEn;
  logic [STAT_BITS-1:0] statusAll;
  logic [STAT_BITS-1:0] pending;

  assign setVec[0] = frameTick;
  assign setVec[1] = |(epEvent & epPriority);
  assign setVec[2] = |(epEvent & ~epPriority);
  assign setVec[3] = busReset | suspendChange | connectChange;

  for (genvar i = 0; i < EVT_BITS; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rstN) evtBits[i] <= 1'b0;
      else       evtBits[i] <= setVec[i] | (evtBits[i] & ~strobe.clrBits[i]);
    end
    // R1, R2, R3, R6: a set always lands, even against a clear
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
      setVec[i] |=> evtBits[i]);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrBits[i] && !setVec[i]) |=> !evtBits[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdEmptyQ <= 1'b1;
      cmdFullQ  <= 1'b0;
      intMask   <= '0;
      globalEn  <= 1'b1;
    end else begin
      cmdEmptyQ <= cmdEmpty;
      cmdFullQ  <= cmdFull;
      if (strobe.maskLoad) intMask  <= wrMask;
      if (strobe.enLoad)   globalEn <= wrEnable;
    end
  end

  assign statusAll = {cmdFullQ, cmdEmptyQ, evtBits};
  assign pending   = statusAll & intMask;
  assign fastIrq   = pending[1];
  assign slowIrq   = pending[2];
  assign irqOut    = globalEn & (|pending);
  assign devStatus = {{(32-STAT_BITS){1'b0}}, statusAll};
  assign topStatus = {globalEn, 22'd0, needClock, 7'd0, |pending};

  assert_fast_route_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|(epEvent & epPriority)) |=> devStatus[1]);
  assert_slow_route_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|(epEvent & ~epPriority)) |=> devStatus[2]);
  assert_cmd_track_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdEmpty |=> devStatus[4]);
endmodule

// File: rtl/usbIntAggregator.sv
module usbIntAggregator
  import usbIntPkg::*;
#(
  parameter int NUM_EP  = 4,
  parameter int HOLD_MS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic [NUM_EP-1:0] epEvent,
  input  logic [NUM_EP-1:0] epPriority,
  input  logic              busReset,
  input  logic              suspendChange,
  input  logic              connectChange,
  input  logic              cmdEmpty,
  input  logic              cmdFull,
  input  logic              busActivity,
  input  logic              frameDone,
  input  logic              msTick,
  input  logic              wakeEnable,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [31:0]       wrData,
  output logic [31:0]       devStatus,
  output logic [31:0]       topStatus,
  output logic [5:0]        intMask,
  output logic              fastIrq,
  output logic              slowIrq,
  output logic              irqOut,
  output logic              wakeReq
);
  ctlStrobe_t strobe;
  logic       needClock;
  logic       unusedWrBits;

  assign unusedWrBits = ^wrData[30:STAT_BITS];

  usbIntCtrl #(.HOLD_MS(HOLD_MS)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regSel      (regSel),
    .wrLow       (wrData[EVT_BITS-1:0]),
    .busActivity (busActivity),
    .frameDone   (frameDone),
    .msTick      (msTick),
    .wakeEnable  (wakeEnable),
    .strobe      (strobe),
    .needClock   (needClock),
    .wakeReq     (wakeReq)
  );

  usbIntDatapath #(.NUM_EP(NUM_EP)) i_data (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrMask        (wrData[STAT_BITS-1:0]),
    .wrEnable      (wrData[31]),
    .frameTick     (frameTick),
    .epEvent       (epEvent),
    .epPriority    (epPriority),
    .busReset      (busReset),
    .suspendChange (suspendChange),
    .connectChange (connectChange),
    .cmdEmpty      (cmdEmpty),
    .cmdFull       (cmdFull),
    .needClock     (needClock),
    .devStatus     (devStatus),
    .topStatus     (topStatus),
    .intMask       (intMask),
    .fastIrq       (fastIrq),
    .slowIrq       (slowIrq),
    .irqOut        (irqOut)
  );

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !topStatus[31] |-> !irqOut);
  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd2) |=> (topStatus[30:9] == 22'd0 && topStatus[7:1] == 7'd0));
endmodule

// File: tb/test_usbIntAggregator.sv
module test_usbIntAggregator;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameTick = 0, busReset = 0, suspendChange = 0, connectChange = 0;
  logic cmdEmpty = 1, cmdFull = 0, busActivity = 0, frameDone = 0, msTick = 0;
  logic wakeEnable = 0, regWrEn = 0;
  logic [3:0] epEvent = '0, epPriority = '0;
  logic [1:0] regSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] devStatus, topStatus;
  logic [5:0] intMask;
  logic fastIrq, slowIrq, irqOut, wakeReq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usbIntAggregator #(.NUM_EP(4), .HOLD_MS(3)) i_usbIntAggregator (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .epEvent(epEvent),
    .epPriority(epPriority), .busReset(busReset), .suspendChange(suspendChange),
    .connectChange(connectChange), .cmdEmpty(cmdEmpty), .cmdFull(cmdFull),
    .busActivity(busActivity), .frameDone(frameDone), .msTick(msTick),
    .wakeEnable(wakeEnable), .regWrEn(regWrEn), .regSel(regSel), .wrData(wrData),
    .devStatus(devStatus), .topStatus(topStatus), .intMask(intMask),
    .fastIrq(fastIrq), .slowIrq(slowIrq), .irqOut(irqOut), .wakeReq(wakeReq));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] data);
    regWrEn = 1; regSel = sel; wrData = data;
    step();
    regWrEn = 0; wrData = '0;
  endtask

  task automatic drivePattern(input logic [3:0] p);
    frameTick = p[0];
    epEvent = {2'b00, p[2], p[1]};
    epPriority = 4'b0001;
    busReset = p[3];
  endtask

  task automatic idleEvents();
    frameTick = 0; epEvent = '0; busReset = 0; suspendChange = 0; connectChange = 0;
  endtask

  task automatic tickMs(input int n);
    for (int k = 0; k < n; k++) begin
      msTick = 1; step(); msTick = 0; step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1;
    #1;
    // R5 reset state
    check("R5 devStatus", devStatus, 32'h0000_0010);
    check("R5 topStatus", topStatus, 32'h8000_0000);
    check("R5 mask/irq/wake", {intMask, irqOut, fastIrq, slowIrq, wakeReq}, '0);

    // R4 command flags registered
    cmdEmpty = 0; cmdFull = 1;
    check("R4 before edge", devStatus[5:4], 2'b01);
    step();
    check("R4 after edge", devStatus[5:4], 2'b10);
    cmdEmpty = 1; cmdFull = 0; step();
    check("R4 restore", devStatus[5:4], 2'b01);

    // R2 sweep of events and priorities
    for (int ev = 0; ev < 16; ev++) begin
      for (int pr = 0; pr < 16; pr++) begin
        writeReg(2'd0, 32'hF);
        epEvent = 4'(ev); epPriority = 4'(pr);
        step();
        epEvent = '0;
        check("R2 routing", devStatus[3:0],
              {28'd0, 1'b0, |(4'(ev) & ~4'(pr)), |(4'(ev) & 4'(pr)), 1'b0});
      end
    end

    // R1 R3 R6 sweep of preset, set and clear in the same cycle
    for (int p = 0; p < 16; p++) begin
      for (int s = 0; s < 16; s++) begin
        for (int c = 0; c < 16; c++) begin
          writeReg(2'd0, 32'hF);
          drivePattern(4'(p)); step(); idleEvents();
          drivePattern(4'(s));
          regWrEn = 1; regSel = 2'd0; wrData = 32'(c) | 32'hFFFF_FFF0;
          step();
          regWrEn = 0; wrData = '0; idleEvents();
          check("R6 set-vs-clear (R1 R3)", devStatus,
                {26'd0, 2'b01, (4'(s) | (4'(p) & ~4'(c)))});
        end
      end
    end

    // R3 the other two bus sources
    writeReg(2'd0, 32'hF);
    suspendChange = 1; step(); suspendChange = 0;
    check("R3 suspend", devStatus[3:0], 32'h8);
    writeReg(2'd0, 32'hF);
    connectChange = 1; step(); connectChange = 0;
    check("R3 connect", devStatus[3:0], 32'h8);

    // R7 R8 R9 mask and enable sweep, status = 0x1F
    drivePattern(4'hF); step(); idleEvents();
    for (int m = 0; m < 64; m++) begin
      for (int en = 0; en < 2; en++) begin
        writeReg(2'd1, 32'(m));
        writeReg(2'd2, {en[0], 31'h7FFF_FFFF});
        check("R7 mask readback", intMask, 32'(m));
        check("R7 fast/slow", {fastIrq, slowIrq}, {m[1], m[2]});
        check("R8 irqOut", irqOut, en[0] & (|(6'(m) & 6'h1F)));
        check("R9 topStatus", topStatus,
              {en[0], 22'd0, 1'b0, 7'd0, |(6'(m) & 6'h1F)});
      end
    end
    writeReg(2'd1, 32'h0);
    writeReg(2'd2, 32'h8000_0000);

    // R10 hold timer
    busActivity = 1; step(); busActivity = 0;
    check("R10 set by activity", topStatus[8], 1);
    for (int k = 1; k <= 3; k++) begin
      msTick = 1; step(); msTick = 0;
      check("R10 countdown", topStatus[8], (k < 3) ? 1 : 0);
      step();
    end
    frameDone = 1; step(); frameDone = 0;
    check("R10 set by frameDone", topStatus[8], 1);
    tickMs(2);
    frameDone = 1; step(); frameDone = 0;
    tickMs(2);
    check("R10 restarted by frame", topStatus[8], 1);
    tickMs(1);
    check("R10 drop after restart", topStatus[8], 0);
    busActivity = 1; step(); busActivity = 0;
    tickMs(2);
    msTick = 1; busActivity = 1; step(); msTick = 0; busActivity = 0;
    check("R10 tick with activity", topStatus[8], 1);
    tickMs(2);
    check("R10 full interval again", topStatus[8], 1);
    tickMs(1);
    check("R10 final drop", topStatus[8], 0);

    // R11 wakeup request
    wakeEnable = 1;
    busActivity = 1; step(); busActivity = 0;
    check("R11 wake on rise", wakeReq, 1);
    step();
    check("R11 wake one cycle", wakeReq, 0);
    busActivity = 1; step(); busActivity = 0;
    check("R11 no wake while high", wakeReq, 0);
    tickMs(3);
    check("R11 flag dropped", topStatus[8], 0);
    wakeEnable = 0;
    busActivity = 1; step(); busActivity = 0;
    check("R11 wake disabled", wakeReq, 0);
    check("R11 flag still rises", topStatus[8], 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule